// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Internal Loopback

This block is a UART-style serial transmitter and receiver. One byte-wide mode register holds the global enable and the loopback select. It also sets the character length, the parity settings, the wakeup method and the idle-line type. A second byte holds the transmitter and receiver enables, the two transmit interrupt enables and the receiver sleep bit. A transmit data write goes through a one-entry buffer in front of the shift register. A received character is held together with its error flags until the host acknowledges it.

A character is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. When parity is on, the top bit of the selected length carries the parity. Bit timing comes from a tick input that pulses at 16 times the baud rate. The receiver starts a character on a low sample and takes a majority vote of three samples around the middle of each bit.

In loop mode the receiver listens to the raw transmit line. The external receive pin then has no effect. Any line encoder or decoder placed outside the block is not in this path. Clearing the global enable stops both serial engines and the tick. It also reports the transmitter as empty and complete, and holds the transmit interrupt low.

Top module: `sci_loop_uart`

## Requirements
- R1: Both control bytes reset to 0. Mode byte (address 0): bit7 loop, bit6 enable, bit5 always reads 0, bit4 nine-bit length, bit3 wake method, bit2 idle type, bit1 parity enable, bit0 odd parity. Second byte (address 1): bit4 sleep, bit3 transmitter enable, bit2 receiver enable, bit1 empty-interrupt enable, bit0 complete-interrupt enable, bits 7..5 always read 0.
- R2: A data write (address 2, with wr_d8 as bit 8) is sent on txd as one low start bit, 8 (length bit 0) or 9 (length bit 1) data bits LSB first, then one high stop bit, each bit lasting 16 ticks. The line rests high.
- R3: With parity enabled, the top bit of the selected length is replaced by a parity bit over the lower bits. Odd parity bit 0 gives even parity and odd parity bit 1 gives odd parity.
- R4: The receiver takes each bit by a majority of three samples near the bit centre, so a one-tick glitch does not change the result. The character appears on rx_data with status bit5 (full) set. Status bit1 (framing) is set when the stop bit is low. rd_ack clears bits 5, 1 and 0.
- R5: With parity enabled, status bit0 is set when the received parity bit disagrees with the selected parity type, and is clear otherwise.
- R6: With the loop bit set, the receiver decodes the transmit line and the state of rxd_pin has no effect on the received data or flags.
- R7: While the enable bit is 0, status bit7 (empty) and bit6 (complete) read 1, tx_irq is 0, txd stays high, and data writes are dropped.
- R8: tx_irq is high when empty-interrupt is enabled and the buffer is empty, or when complete-interrupt is enabled and the transmitter is empty and idle.
- R9: Status bit4 (idle) is set after one full character time of high line following a received character. With idle type 0 the count runs from the end of the start bit, and with idle type 1 it runs from the stop bit.
- R10: While the sleep bit is set, received characters are not stored. With wake method 0 a detected idle line clears the sleep bit. With wake method 1 a character whose top bit is 1 clears it and is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Pulse at 16 times the baud rate |
| rxd_pin | input | 1 | External serial receive line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 mode, 1 second control byte, 2 transmit data |
| wr_data | input | 8 | Write data |
| wr_d8 | input | 1 | Ninth transmit data bit |
| rd_ack | input | 1 | Acknowledge received character, clears full and error flags |
| ctrl1_q | output | 8 | Mode byte readback |
| ctrl2_q | output | 8 | Second control byte readback |
| status | output | 8 | bit7 empty, bit6 complete, bit5 full, bit4 idle, bit1 framing, bit0 parity |
| rx_data | output | 9 | Last stored received character |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The checker watches several rules on every cycle. The reserved control bits stay 0. A disabled block reports empty and complete with the interrupt low. The line is high whenever the transmitter is complete. The interrupt only rises with an enabled source. A stored character needs an active receiver, and a character stored during sleep needs an address mark in wake method 1. The bench scenarios are needed for the rest: frame shape and bit order, parity placement, majority-vote glitch rejection, framing and parity errors, the two idle-count start points, idle and address wakeup, and loopback with the receive pin held low.

// File: rtl/sci_pkg.sv
package sci_pkg;
   // mode byte fields
   localparam int M_LOOP  = 7;
   localparam int M_EN    = 6;
   localparam int M_NINE  = 4;
   localparam int M_WAKE  = 3;
   localparam int M_ILTY  = 2;
   localparam int M_PEN   = 1;
   localparam int M_ODD   = 0;
   // second control byte fields
   localparam int C_SLEEP = 4;
   localparam int C_TE    = 3;
   localparam int C_RE    = 2;
   localparam int C_TIE   = 1;
   localparam int C_TCIE  = 0;

   typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

   // character as it goes on the line: parity replaces the top bit when enabled
   function automatic logic [8:0] sci_payload(input logic [8:0] d, input logic nine,
                                              input logic pen, input logic odd);
      logic p;
      logic [8:0] r;
      if (nine) begin
         p = (^d[7:0]) ^ odd;
         r = pen ? {p, d[7:0]} : d;
      end else begin
         p = (^d[6:0]) ^ odd;
         r = pen ? {1'b0, p, d[6:0]} : {1'b0, d[7:0]};
      end
      return r;
   endfunction
endpackage

// File: rtl/sci_tx.sv
module sci_tx import sci_pkg::*; #(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       start,
   input  logic       nine,
   input  logic [8:0] payload,
   output logic       busy,
   output logic       take,
   output logic       line
);
   localparam int SW = $clog2(OSR);
   localparam int FW = 11;

   logic [SW-1:0] sub_q;
   logic [3:0]    bit_q;
   logic [FW-1:0] sh_q;
   logic          nine_q;
   logic [3:0]    last;

   assign last = nine_q ? 4'd10 : 4'd9;
   assign take = run & ~busy & start;
   assign line = (busy & run) ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sub_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '1;
         nine_q <= 1'b0;
      end else if (!run) begin
         busy <= 1'b0;
         sh_q <= '1;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            sub_q  <= '0;
            bit_q  <= '0;
            nine_q <= nine;
            sh_q   <= nine ? {1'b1, payload, 1'b0} : {2'b11, payload[7:0], 1'b0};
         end
      end else if (tick) begin
         if (sub_q == SW'(OSR - 1)) begin
            sub_q <= '0;
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            bit_q <= bit_q + 4'd1;
            if (bit_q == last) busy <= 1'b0;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sci_rx.sv
module sci_rx import sci_pkg::*; #(
   parameter int OSR      = 16,
   parameter bit MAJORITY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       rxi,
   input  logic       nine,
   output logic       done,
   output logic       active,
   output logic       stop_ok,
   output logic [8:0] word
);
   localparam int SW  = $clog2(OSR);
   localparam int MID = OSR / 2;

   rx_state_t     st_q;
   logic [SW-1:0] sub_q;
   logic [3:0]    bit_q;
   logic [8:0]    sh_q;
   logic          s1_q, s2_q, nine_q, vote;
   logic [3:0]    last;

   generate
      if (MAJORITY) begin : g_vote3
         assign vote = (s1_q & s2_q) | (s1_q & rxi) | (s2_q & rxi);
      end else begin : g_vote1
         assign vote = s2_q;
      end
   endgenerate

   assign last   = nine_q ? 4'd10 : 4'd9;
   assign active = (st_q == RX_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         sub_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         s1_q    <= 1'b1;
         s2_q    <= 1'b1;
         nine_q  <= 1'b0;
         done    <= 1'b0;
         stop_ok <= 1'b1;
         word    <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            st_q <= RX_IDLE;
         end else if (tick) begin
            case (st_q)
               RX_IDLE: if (!rxi) begin
                  st_q   <= RX_BUSY;
                  sub_q  <= '0;
                  bit_q  <= '0;
                  nine_q <= nine;
               end
               default: begin
                  sub_q <= (sub_q == SW'(OSR - 1)) ? '0 : sub_q + 1'b1;
                  if (sub_q == SW'(OSR - 1)) bit_q <= bit_q + 4'd1;
                  if (sub_q == SW'(MID - 1)) s1_q <= rxi;
                  if (sub_q == SW'(MID))     s2_q <= rxi;
                  if (sub_q == SW'(MID + 1)) begin
                     if (bit_q == 4'd0) begin
                        if (vote) st_q <= RX_IDLE;   // false start
                     end else if (bit_q == last) begin
                        done    <= 1'b1;
                        stop_ok <= vote;
                        word    <= nine_q ? sh_q : {1'b0, sh_q[8:1]};
                        st_q    <= RX_IDLE;
                     end else begin
                        sh_q <= {vote, sh_q[8:1]};
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/sci_loop_uart.sv
module sci_loop_uart import sci_pkg::*; #(
   parameter int OSR      = 16,
   parameter bit MAJORITY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rxd_pin,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       wr_d8,
   input  logic       rd_ack,
   output logic [7:0] ctrl1_q,
   output logic [7:0] ctrl2_q,
   output logic [7:0] status,
   output logic [8:0] rx_data,
   output logic       txd,
   output logic       tx_irq
);
   localparam int IW = $clog2(OSR * 11 + 1);

   generate
      if (OSR < 8) begin : g_bad_osr
         $error("sci_loop_uart: OSR must be at least 8");
      end
   endgenerate

   logic en, loops, nine, wake, ilty, pen, odd, sleep, te, re, tie, tcie;
   logic tick_g, run_rx, rx_in;
   logic tx_busy, tx_take, tx_line, buf_full;
   logic [8:0] buf_q, rx_word;
   logic rx_done, rx_act, rx_stop, msb, addr_hit, accept, idle_set;
   logic rx_full, fe_q, pe_q, idle_q, arm_q;
   logic [IW-1:0] icnt, thr;

   assign en    = ctrl1_q[M_EN];
   assign loops = ctrl1_q[M_LOOP];
   assign nine  = ctrl1_q[M_NINE];
   assign wake  = ctrl1_q[M_WAKE];
   assign ilty  = ctrl1_q[M_ILTY];
   assign pen   = ctrl1_q[M_PEN];
   assign odd   = ctrl1_q[M_ODD];
   assign sleep = ctrl2_q[C_SLEEP];
   assign te    = ctrl2_q[C_TE];
   assign re    = ctrl2_q[C_RE];
   assign tie   = ctrl2_q[C_TIE];
   assign tcie  = ctrl2_q[C_TCIE];

   assign tick_g = tick16 & en;
   assign run_rx = en & re;
   assign rx_in  = loops ? tx_line : rxd_pin;
   assign txd    = tx_line;

   sci_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .run(en), .tick(tick_g), .start(buf_full & te),
      .nine(nine), .payload(buf_q), .busy(tx_busy), .take(tx_take), .line(tx_line));

   sci_rx #(.OSR(OSR), .MAJORITY(MAJORITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .run(run_rx), .tick(tick_g), .rxi(rx_in), .nine(nine),
      .done(rx_done), .active(rx_act), .stop_ok(rx_stop), .word(rx_word));

   assign msb      = nine ? rx_word[8] : rx_word[7];
   assign addr_hit = wake & msb;
   assign accept   = rx_done & (~sleep | addr_hit);
   assign thr      = nine ? IW'(OSR * 11) : IW'(OSR * 10);
   assign idle_set = run_rx & rx_in & ~(rx_act & ilty) & tick_g &
                     (icnt == thr - 1'b1) & (arm_q | rx_done);

   // control bytes and transmit buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl1_q  <= '0;
         ctrl2_q  <= '0;
         buf_full <= 1'b0;
         buf_q    <= '0;
      end else begin
         if (wr_en && wr_addr == 2'd0) ctrl1_q <= wr_data & 8'hDF;
         if (wr_en && wr_addr == 2'd1) ctrl2_q <= wr_data & 8'h1F;
         else if ((accept & addr_hit) | (idle_set & ~wake)) ctrl2_q[C_SLEEP] <= 1'b0;
         if (!en) begin
            buf_full <= 1'b0;
         end else if (wr_en && wr_addr == 2'd2) begin
            buf_full <= 1'b1;
            buf_q    <= sci_payload({wr_d8, wr_data}, nine, pen, odd);
         end else if (tx_take) begin
            buf_full <= 1'b0;
         end
      end
   end

   // receive flags and idle-line detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         fe_q    <= 1'b0;
         pe_q    <= 1'b0;
         rx_data <= '0;
         icnt    <= '0;
         idle_q  <= 1'b0;
         arm_q   <= 1'b0;
      end else begin
         if (accept) begin
            rx_full <= 1'b1;
            rx_data <= rx_word;
            fe_q    <= ~rx_stop;
            pe_q    <= pen & (rx_word != sci_payload(rx_word, nine, 1'b1, odd));
         end else if (rd_ack) begin
            rx_full <= 1'b0;
            fe_q    <= 1'b0;
            pe_q    <= 1'b0;
         end
         if (!run_rx) begin
            icnt   <= '0;
            idle_q <= 1'b0;
            arm_q  <= 1'b0;
         end else begin
            if (rx_done) arm_q <= 1'b1;
            if (!rx_in) begin
               icnt   <= '0;
               idle_q <= 1'b0;
            end else if (rx_act & ilty) begin
               icnt <= '0;
            end else if (tick_g && icnt != thr) begin
               icnt <= icnt + 1'b1;
            end
            if (idle_set) begin
               idle_q <= 1'b1;
               arm_q  <= 1'b0;
            end
         end
      end
   end

   assign status = {~en | ~buf_full, ~en | (~buf_full & ~tx_busy), rx_full, idle_q,
                    2'b00, fe_q, pe_q};
   assign tx_irq = en & ((tie & ~buf_full) | (tcie & ~buf_full & ~tx_busy));
endmodule

// File: rtl/sci_loop_uart_chk.sv
module sci_loop_uart_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctrl1_q,
   input logic [7:0] ctrl2_q,
   input logic [7:0] status,
   input logic [8:0] rx_data,
   input logic       txd,
   input logic       tx_irq
);
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl1_q[5] == 1'b0 && ctrl2_q[7:5] == 3'b000);

   a_r7_disabled_forces: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl1_q[6] |-> status[7] && status[6] && !tx_irq);

   a_r2_line_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> txd);

   a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (ctrl2_q[1] && status[7]) || (ctrl2_q[0] && status[6]));

   a_r4_store_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[5]) |-> $past(ctrl1_q[6] && ctrl2_q[2]));

   a_r10_sleep_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[5]) && $past(ctrl2_q[4]) |->
         $past(ctrl1_q[3]) && (ctrl1_q[4] ? rx_data[8] : rx_data[7]));
endmodule

bind sci_loop_uart sci_loop_uart_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q),
   .status(status), .rx_data(rx_data), .txd(txd), .tx_irq(tx_irq));

// File: tb/sci_loop_uart_bench.sv
module sci_loop_uart_bench;
   logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b1, rxd_pin = 1'b1;
   logic wr_en = 1'b0, wr_d8 = 1'b0, rd_ack = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] ctrl1_q, ctrl2_q, status;
   logic [8:0] rx_data;
   logic txd, tx_irq;
   bit   jitter = 1'b0;
   int   total = 0, bad = 0;

   sci_loop_uart u_sci_loop_uart (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_pin(rxd_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_d8(wr_d8),
      .rd_ack(rd_ack), .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .status(status),
      .rx_data(rx_data), .txd(txd), .tx_irq(tx_irq));

   always #10 clk = ~clk;

   always @(negedge clk) tick16 <= jitter ? ($urandom_range(0, 3) != 0) : 1'b1;

   initial begin
      #(20 * 190000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic d8);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_d8 = d8;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 8000 && status[6] !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic wait_full();
      for (int i = 0; i < 8000 && status[5] !== 1'b1; i++) @(negedge clk);
   endtask

   function automatic logic [8:0] exp_payload(input logic [8:0] d, input bit nine,
                                              input bit pen, input bit odd);
      int n;
      int ones;
      logic [8:0] r;
      n = nine ? 9 : 8;
      ones = 0;
      r = '0;
      for (int i = 0; i < n; i++) r[i] = d[i];
      if (pen) begin
         for (int i = 0; i < n - 1; i++) ones += int'(d[i]);
         r[n-1] = ((ones % 2) == 1) ^ odd;
      end
      return r;
   endfunction

   function automatic logic [10:0] exp_frame(input logic [8:0] p, input bit nine);
      logic [10:0] f;
      int n;
      n = nine ? 9 : 8;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < n; i++) f[i+1] = p[i];
      return f;
   endfunction

   task automatic cap_tx(input bit nine, output logic [10:0] f);
      int n;
      n = nine ? 11 : 10;
      f = '1;
      for (int i = 0; i < 400 && txd !== 1'b0; i++) @(negedge clk);
      repeat (8) @(negedge clk);
      f[0] = txd;
      for (int i = 1; i < n; i++) begin
         repeat (16) @(negedge clk);
         f[i] = txd;
      end
   endtask

   // drive one frame onto rxd_pin; glitch flips one cycle mid-bit of bit index gb
   task automatic send_pin(input logic [8:0] p, input bit nine, input bit stopv, input int gb);
      int n;
      logic v;
      n = nine ? 9 : 8;
      for (int k = 0; k < n + 2; k++) begin
         v = (k == 0) ? 1'b0 : (k == n + 1) ? stopv : p[k-1];
         for (int j = 0; j < 16; j++) begin
            rxd_pin = (k == gb && j == 9) ? ~v : v;
            @(negedge clk);
         end
      end
      rxd_pin = 1'b1;
   endtask

   initial begin
      logic [10:0] fr;
      logic [8:0]  pl, d;
      bit m, pe, po;
      int lows;
      void'($urandom(32'd2024));

      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      // R1 / R7 reset state
      check("R1 mode reset", {8'h0, ctrl1_q}, 16'h0);
      check("R1 ctrl2 reset", {8'h0, ctrl2_q}, 16'h0);
      check("R7 reset status", {8'h0, status}, 16'h00C0);
      check("R7 reset irq/txd", {14'h0, tx_irq, txd}, 16'h1);
      wr(2'd0, 8'hFF, 1'b0);
      check("R1 bit5 reads 0", {8'h0, ctrl1_q}, 16'h00DF);
      wr(2'd1, 8'hFF, 1'b0);
      check("R1 ctrl2 mask", {8'h0, ctrl2_q}, 16'h001F);
      wr(2'd0, 8'h00, 1'b0);
      wr(2'd1, 8'h0B, 1'b0);

      // R7 disabled: write dropped, line high
      wr(2'd2, 8'h5A, 1'b0);
      lows = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R7 txd high while off", 16'(lows), 16'd0);
      check("R7 flags while off", {7'h0, tx_irq, status}, 16'h00C0);
      wr(2'd0, 8'h40, 1'b0);
      cycles(2);
      check("R7 dropped write", {14'h0, status[7], txd}, 16'h3);
      check("R8 empty irq", {15'h0, tx_irq}, 16'h1);

      // R8 interrupt sources
      wr(2'd1, 8'h02, 1'b0);
      wr(2'd2, 8'h11, 1'b0);
      cycles(2);
      check("R8 buffer full no irq", {14'h0, status[7], tx_irq}, 16'h0);
      wr(2'd1, 8'h01, 1'b0);
      check("R8 tcie busy no irq", {15'h0, tx_irq}, 16'h0);
      wr(2'd1, 8'h09, 1'b0);
      cycles(3);
      check("R8 sending", {13'h0, status[7], status[6], tx_irq}, 16'h4);
      wait_done();
      cycles(1);
      check("R8 complete irq", {15'h0, tx_irq}, 16'h1);
      wr(2'd0, 8'h00, 1'b0);
      check("R7 disable masks irq", {7'h0, tx_irq, status}, 16'h00C0);

      // R2 frame shape, R3 parity
      wr(2'd0, 8'h40, 1'b0);
      wr(2'd1, 8'h08, 1'b0);
      wr(2'd2, 8'hA5, 1'b0);
      cap_tx(1'b0, fr);
      check("R2 8-bit frame", {5'h0, fr}, {5'h0, exp_frame(9'h0A5, 1'b0)});
      wait_done();
      wr(2'd0, 8'h50, 1'b0);
      wr(2'd2, 8'h3C, 1'b1);
      cap_tx(1'b1, fr);
      check("R2 9-bit frame", {5'h0, fr}, {5'h0, exp_frame(9'h13C, 1'b1)});
      wait_done();
      for (int c = 0; c < 3; c++) begin
         m  = (c == 2);
         po = (c != 0);
         d  = 9'h037 + 9'(c * 9'h055);
         wr(2'd0, 8'h42 | (m ? 8'h10 : 8'h0) | (po ? 8'h01 : 8'h0), 1'b0);
         wr(2'd2, d[7:0], d[8]);
         cap_tx(m, fr);
         check("R3 parity frame", {5'h0, fr},
               {5'h0, exp_frame(exp_payload(d, m, 1'b1, po), m)});
         wait_done();
      end

      // R4 receive from pin
      wr(2'd0, 8'h40, 1'b0);
      wr(2'd1, 8'h04, 1'b0);
      send_pin(9'h0C9, 1'b0, 1'b1, -1);
      cycles(2);
      check("R4 rx data", {7'h0, rx_data}, 16'h00C9);
      check("R4 rx flags", {13'h0, status[5], status[1], status[0]}, 16'h4);
      ack();
      check("R4 ack clears", {15'h0, status[5]}, 16'h0);
      send_pin(9'h096, 1'b0, 1'b1, 4);
      cycles(2);
      check("R4 glitch rejected", {7'h0, rx_data}, 16'h0096);
      ack();
      send_pin(9'h03E, 1'b0, 1'b0, -1);
      cycles(2);
      check("R4 framing error", {6'h0, status[1], rx_data}, {6'h0, 1'b1, 9'h03E});
      ack();

      // R5 parity check on receive
      wr(2'd0, 8'h42, 1'b0);
      pl = exp_payload(9'h05B, 1'b0, 1'b1, 1'b0);
      send_pin(pl, 1'b0, 1'b1, -1);
      cycles(2);
      check("R5 good parity", {14'h0, status[5], status[0]}, 16'h2);
      ack();
      send_pin(pl ^ 9'h080, 1'b0, 1'b1, -1);
      cycles(2);
      check("R5 bad parity", {14'h0, status[5], status[0]}, 16'h3);
      ack();

      // R9 idle detection, both types
      wr(2'd0, 8'h40, 1'b0);
      send_pin(9'h0FF, 1'b0, 1'b1, -1);
      cycles(32);
      check("R9 idle type0 early", {15'h0, status[4]}, 16'h1);
      ack();
      wr(2'd0, 8'h44, 1'b0);
      send_pin(9'h0FF, 1'b0, 1'b1, -1);
      cycles(32);
      check("R9 idle type1 not yet", {15'h0, status[4]}, 16'h0);
      cycles(180);
      check("R9 idle type1 later", {15'h0, status[4]}, 16'h1);
      ack();

      // R10 wakeup
      wr(2'd0, 8'h40, 1'b0);
      wr(2'd1, 8'h14, 1'b0);
      send_pin(9'h033, 1'b0, 1'b1, -1);
      cycles(2);
      check("R10 asleep idle mode", {14'h0, status[5], ctrl2_q[4]}, 16'h1);
      cycles(200);
      check("R10 idle wakes", {15'h0, ctrl2_q[4]}, 16'h0);
      send_pin(9'h044, 1'b0, 1'b1, -1);
      cycles(2);
      check("R10 after idle wake", {6'h0, status[5], rx_data}, {6'h0, 1'b1, 9'h044});
      ack();
      wr(2'd0, 8'h48, 1'b0);
      wr(2'd1, 8'h14, 1'b0);
      send_pin(9'h012, 1'b0, 1'b1, -1);
      cycles(200);
      check("R10 no mark stays asleep", {14'h0, status[5], ctrl2_q[4]}, 16'h1);
      send_pin(9'h085, 1'b0, 1'b1, -1);
      cycles(2);
      check("R10 mark wakes", {5'h0, status[5], ctrl2_q[4], rx_data},
            {5'h0, 1'b1, 1'b0, 9'h085});
      ack();

      // R6 loopback with pin held low, random configs and tick gaps
      wr(2'd1, 8'h0C, 1'b0);
      wr(2'd0, 8'hC0, 1'b0);
      rxd_pin = 1'b0;
      cycles(40);
      ack();
      jitter = 1'b1;
      for (int it = 0; it < 16; it++) begin
         m  = 1'($urandom_range(0, 1));
         pe = 1'($urandom_range(0, 1));
         po = 1'($urandom_range(0, 1));
         d  = 9'($urandom_range(0, 511));
         if (it == 0) begin m = 1'b0; pe = 1'b0; d = 9'h000; end
         wr(2'd0, 8'hC0 | {3'b0, m, 2'b0, pe, po}, 1'b0);
         wr(2'd2, d[7:0], d[8]);
         wait_full();
         cycles(1);
         check("R6 loop data", {7'h0, rx_data}, {7'h0, exp_payload(d, m, pe, po)});
         check("R6 loop flags", {13'h0, status[5], status[1], status[0]}, 16'h4);
         ack();
         wait_done();
         cycles(40);
      end
      jitter = 1'b0;
      rxd_pin = 1'b1;
      cycles(4);
      wr(2'd0, 8'h40, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule